// File: doc/BRIEF.md
# Sector Protection and Lockdown Unit

This unit keeps the write-protection state of a 2-Mbyte storage array split into 32 equal 64-Kbyte sectors. Each sector carries a protect bit and a lockdown bit. Software-level commands set or clear single protect bits, set or clear all of them at once, or lock a sector for good. A locked sector stays read-only until a full system reset, which here stands in for non-volatile storage. An active-low write-protect input blocks every request that would lower protection.

Before any program or erase operation runs, the controller presents it to the unit as a kind and a 21-bit byte address. One cycle later the unit answers permit or reject and updates a sticky error flag. The sector is taken from the top address bits. A 4-Kbyte or 32-Kbyte erase is judged by the one sector that holds it. A full-chip erase needs every sector to be open. Both bit maps are always visible on output ports.

Top module: `sector_guard`

## Requirements
- R1: After reset, all 32 protect bits read 1, all lock bits read 0, `rsp_valid` is 0 and `err_flag` is 0.
- R2: A command with `cmd_op`=1 (protect) or `cmd_op`=2 (unprotect) sets or clears only the protect bit of sector `cmd_addr[20:16]`. The change shows on `prot_map` the cycle after the command. Op codes 0, 6 and 7 change nothing.
- R3: `cmd_op`=3 sets every protect bit. `cmd_op`=4 clears every protect bit except those of locked sectors.
- R4: `cmd_op`=5 sets both the lock bit and the protect bit of sector `cmd_addr[20:16]`. A lock bit never returns to 0 except through reset, and unprotect commands leave a locked sector protected.
- R5: While `wp_n` is 0, commands 2 and 4 leave `prot_map` unchanged. Commands 1, 3 and 5 still take effect.
- R6: A check with `chk_kind` 0 (program), 1 (4K erase), 2 (32K erase) or 3 (64K erase) is permitted exactly when sector `chk_addr[20:16]` is neither protected nor locked. `rsp_valid` and `rsp_permit` appear the cycle after `chk_valid`.
- R7: A check with `chk_kind`=4 (full-chip erase) is permitted only when no sector is protected or locked.
- R8: `err_flag` is set by a rejected check and stays set until a later check is permitted.
- R9: When a command and a check arrive in the same cycle, the check is judged on the state from before that command.
- R10: A check with `chk_kind` 5, 6 or 7 is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wp_n | input | 1 | Write-protect, active low; blocks lowering of protection |
| cmd_valid | input | 1 | Protection command strobe |
| cmd_op | input | 3 | Command code (see R2-R5) |
| cmd_addr | input | 21 | Byte address selecting the target sector |
| chk_valid | input | 1 | Program/erase check strobe |
| chk_kind | input | 3 | Operation kind (see R6, R7, R10) |
| chk_addr | input | 21 | Byte address of the operation |
| rsp_valid | output | 1 | Check answer valid, one cycle after `chk_valid` |
| rsp_permit | output | 1 | 1 = operation allowed, 0 = rejected |
| err_flag | output | 1 | Sticky failure indication |
| prot_map | output | 32 | Per-sector protect bits, bit i = sector i |
| lock_map | output | 32 | Per-sector lockdown bits, bit i = sector i |

## Verification
The assertions assume that `wp_n`, the command inputs and the check inputs are driven clean between clock edges. They also assume that the addresses only ever select a sector through their top five bits, so any 21-bit value is legal. The properties judge a check only against the maps as they stood in the cycle of the request. The bench therefore changes inputs on falling edges and reads answers one full cycle later. It keeps the check in the same cycle as a command only in the one case built to show R9.

// File: rtl/sguard_pkg.sv
package sguard_pkg;
  localparam int ADDR_W_DEF = 21;
  localparam int SECT_W_DEF = 5;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PROT    = 3'd1,
    OP_UNPROT  = 3'd2,
    OP_GPROT   = 3'd3,
    OP_GUNPROT = 3'd4,
    OP_LOCK    = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    K_PROG  = 3'd0,
    K_E4K   = 3'd1,
    K_E32K  = 3'd2,
    K_E64K  = 3'd3,
    K_CHIP  = 3'd4
  } kind_e;

  // operation that touches a single sector
  function automatic logic one_sector_kind(logic [2:0] k);
    return (k == K_PROG) || (k == K_E4K) || (k == K_E32K) || (k == K_E64K);
  endfunction

  // command that lowers protection (gated by write-protect)
  function automatic logic lowers_prot(logic [2:0] op);
    return (op == OP_UNPROT) || (op == OP_GUNPROT);
  endfunction
endpackage

// File: rtl/sguard_bank.sv
module sguard_bank #(
  parameter int SECT_W = sguard_pkg::SECT_W_DEF,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [SECT_W-1:0] sel,
  output logic [NSECT-1:0]  prot_q,
  output logic [NSECT-1:0]  lock_q,
  output logic              unprot_refused
);
  import sguard_pkg::*;

  logic go_prot, go_unprot, go_gprot, go_gunprot, go_lock;

  always_comb begin
    go_prot    = cmd_valid && (cmd_op == OP_PROT);
    go_unprot  = cmd_valid && (cmd_op == OP_UNPROT)  && wp_n;
    go_gprot   = cmd_valid && (cmd_op == OP_GPROT);
    go_gunprot = cmd_valid && (cmd_op == OP_GUNPROT) && wp_n;
    go_lock    = cmd_valid && (cmd_op == OP_LOCK);
  end

  assign unprot_refused = cmd_valid && !wp_n && lowers_prot(cmd_op);

  for (genvar i = 0; i < NSECT; i++) begin : g_sect
    localparam logic [SECT_W-1:0] IDX = SECT_W'(i);
    logic hit, set_p, clr_p, set_l;

    always_comb begin
      hit   = (sel == IDX);
      set_l = go_lock && hit;
      set_p = (go_prot && hit) || go_gprot || set_l;
      clr_p = ((go_unprot && hit) || go_gunprot) && !lock_q[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prot_q[i] <= 1'b1;
        lock_q[i] <= 1'b0;
      end else begin
        if (set_p)      prot_q[i] <= 1'b1;
        else if (clr_p) prot_q[i] <= 1'b0;
        if (set_l)      lock_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sguard_check.sv
module sguard_check #(
  parameter int SECT_W = sguard_pkg::SECT_W_DEF,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [2:0]        chk_kind,
  input  logic [SECT_W-1:0] sel,
  input  logic [NSECT-1:0]  prot_q,
  input  logic [NSECT-1:0]  lock_q,
  output logic              rsp_valid,
  output logic              rsp_permit,
  output logic              err_flag,
  output logic              permit_now
);
  import sguard_pkg::*;

  logic sector_open, array_open;

  always_comb begin
    sector_open = !(prot_q[sel] || lock_q[sel]);
    array_open  = ~|(prot_q | lock_q);
    if (one_sector_kind(chk_kind))  permit_now = sector_open;
    else if (chk_kind == K_CHIP)    permit_now = array_open;
    else                            permit_now = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_permit <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      rsp_valid <= chk_valid;
      if (chk_valid) begin
        rsp_permit <= permit_now;
        err_flag   <= !permit_now;
      end
    end
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int ADDR_W = sguard_pkg::ADDR_W_DEF,
  parameter int SECT_W = sguard_pkg::SECT_W_DEF,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              chk_valid,
  input  logic [2:0]        chk_kind,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              rsp_valid,
  output logic              rsp_permit,
  output logic              err_flag,
  output logic [NSECT-1:0]  prot_map,
  output logic [NSECT-1:0]  lock_map
);
  logic [SECT_W-1:0] cmd_sel, chk_sel;
  logic              unprot_refused;
  logic              permit_now;

  assign cmd_sel = cmd_addr[ADDR_W-1 -: SECT_W];
  assign chk_sel = chk_addr[ADDR_W-1 -: SECT_W];

  sguard_bank #(.SECT_W(SECT_W)) u_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .wp_n           (wp_n),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .sel            (cmd_sel),
    .prot_q         (prot_map),
    .lock_q         (lock_map),
    .unprot_refused (unprot_refused)
  );

  sguard_check #(.SECT_W(SECT_W)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_valid  (chk_valid),
    .chk_kind   (chk_kind),
    .sel        (chk_sel),
    .prot_q     (prot_map),
    .lock_q     (lock_map),
    .rsp_valid  (rsp_valid),
    .rsp_permit (rsp_permit),
    .err_flag   (err_flag),
    .permit_now (permit_now)
  );
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk #(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 5,
  localparam int NSECT = 1 << SECT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              chk_valid,
  input logic [2:0]        chk_kind,
  input logic [ADDR_W-1:0] chk_addr,
  input logic              rsp_valid,
  input logic              rsp_permit,
  input logic              err_flag,
  input logic [NSECT-1:0]  prot_map,
  input logic [NSECT-1:0]  lock_map,
  input logic              unprot_refused
);
  logic [SECT_W-1:0] idx;
  assign idx = chk_addr[ADDR_W-1 -: SECT_W];

  // R4
  lock_keeps_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_map & ~prot_map) == '0);

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((lock_map & $past(lock_map)) == $past(lock_map)));

  // R5
  wp_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unprot_refused |=> (prot_map == $past(prot_map)));

  // R3
  gprot_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3) |=> (&prot_map));

  // R6
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid);

  // R6
  sector_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_kind <= 3'd3 && prot_map[idx]) |=> !rsp_permit);

  // R6
  sector_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_kind <= 3'd3 && !prot_map[idx] && !lock_map[idx]) |=> rsp_permit);

  // R7
  chip_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_kind == 3'd4 && (|prot_map)) |=> !rsp_permit);

  // R10
  bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_kind > 3'd4) |=> !rsp_permit);

  // R8
  err_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_permit) |-> err_flag);
endmodule

bind sector_guard sector_guard_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_op         (cmd_op),
  .chk_valid      (chk_valid),
  .chk_kind       (chk_kind),
  .chk_addr       (chk_addr),
  .rsp_valid      (rsp_valid),
  .rsp_permit     (rsp_permit),
  .err_flag       (err_flag),
  .prot_map       (prot_map),
  .lock_map       (lock_map),
  .unprot_refused (unprot_refused)
);

// File: tb/sector_guard_bench.sv
module sector_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [20:0] cmd_addr = '0;
  logic        chk_valid = 1'b0;
  logic [2:0]  chk_kind = 3'd0;
  logic [20:0] chk_addr = '0;
  logic        rsp_valid, rsp_permit, err_flag;
  logic [31:0] prot_map, lock_map;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] m_prot, m_lock;

  always #2 clk = ~clk;

  sector_guard u_sector_guard (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .chk_valid(chk_valid), .chk_kind(chk_kind), .chk_addr(chk_addr),
    .rsp_valid(rsp_valid), .rsp_permit(rsp_permit), .err_flag(err_flag),
    .prot_map(prot_map), .lock_map(lock_map)
  );

  task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] sec_addr(int s, int off);
    return {5'(s), 16'(off)};
  endfunction

  // independent model of the requirements
  task automatic model_cmd(logic [2:0] op, logic [20:0] a);
    int s = int'(a[20:16]);
    case (op)
      3'd1: m_prot[s] = 1'b1;
      3'd2: if (wp_n && !m_lock[s]) m_prot[s] = 1'b0;
      3'd3: m_prot = '1;
      3'd4: if (wp_n) m_prot = m_lock;
      3'd5: begin m_prot[s] = 1'b1; m_lock[s] = 1'b1; end
      default: ;
    endcase
  endtask

  function automatic logic model_permit(logic [2:0] k, logic [20:0] a);
    if (k <= 3'd3) return !(m_prot[a[20:16]] || m_lock[a[20:16]]);
    if (k == 3'd4) return (m_prot | m_lock) == '0;
    return 1'b0;
  endfunction

  task automatic do_cmd(string tag, logic [2:0] op, logic [20:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_cmd(op, a);
    expect_eq(tag, prot_map, m_prot);
    expect_eq(tag, lock_map, m_lock);
  endtask

  task automatic do_chk(string tag, logic [2:0] k, logic [20:0] a);
    logic exp_p;
    exp_p = model_permit(k, a);
    @(negedge clk);
    chk_valid = 1'b1; chk_kind = k; chk_addr = a;
    @(negedge clk);
    chk_valid = 1'b0;
    expect_eq(tag, {31'd0, rsp_valid}, 32'd1);
    expect_eq(tag, {31'd0, rsp_permit}, {31'd0, exp_p});
    expect_eq("R8", {31'd0, err_flag}, {31'd0, !exp_p});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_prot = '1; m_lock = '0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_eq("R1", prot_map, 32'hFFFF_FFFF);
    expect_eq("R1", lock_map, 32'h0);
    expect_eq("R1", {30'd0, rsp_valid, err_flag}, 32'h0);
  endtask

  task automatic t_single();
    do_cmd("R2", 3'd2, sec_addr(3, 16'h1234));
    do_cmd("R2", 3'd2, sec_addr(30, 0));
    do_cmd("R2", 3'd1, sec_addr(3, 16'hFFFF));
    do_cmd("R2", 3'd0, sec_addr(5, 0));
    do_cmd("R2", 3'd6, sec_addr(5, 0));
    do_cmd("R2", 3'd7, sec_addr(30, 0));
  endtask

  task automatic t_global();
    do_cmd("R3", 3'd4, 21'd0);
    expect_eq("R3", prot_map, 32'h0);
    do_cmd("R3", 3'd3, 21'd0);
    expect_eq("R3", prot_map, 32'hFFFF_FFFF);
  endtask

  task automatic t_chip();
    do_cmd("R3", 3'd4, 21'd0);
    do_chk("R7", 3'd4, 21'd0);
    do_cmd("R2", 3'd1, sec_addr(17, 0));
    do_chk("R7", 3'd4, 21'h1F_FFFF);
  endtask

  task automatic t_access();
    do_chk("R6", 3'd0, sec_addr(7, 16'h00FF));
    do_cmd("R2", 3'd1, sec_addr(7, 0));
    do_chk("R6", 3'd1, sec_addr(7, 16'hF000));
    do_chk("R6", 3'd2, sec_addr(7, 16'h8000));
    do_chk("R6", 3'd3, sec_addr(8, 0));
    do_chk("R6", 3'd0, sec_addr(17, 16'h0001));
    do_chk("R6", 3'd3, sec_addr(31, 16'hFFFF));
  endtask

  task automatic t_wp();
    wp_n = 1'b0;
    do_cmd("R5", 3'd2, sec_addr(7, 0));
    expect_eq("R5", {31'd0, prot_map[7]}, 32'd1);
    do_cmd("R5", 3'd4, 21'd0);
    do_cmd("R5", 3'd1, sec_addr(20, 0));
    do_cmd("R5", 3'd5, sec_addr(21, 0));
    do_cmd("R5", 3'd3, 21'd0);
    wp_n = 1'b1;
  endtask

  task automatic t_lock();
    do_cmd("R4", 3'd5, sec_addr(0, 0));
    do_cmd("R4", 3'd5, sec_addr(31, 0));
    do_cmd("R4", 3'd2, sec_addr(31, 0));
    expect_eq("R4", {31'd0, prot_map[31]}, 32'd1);
    do_cmd("R4", 3'd4, 21'd0);
    expect_eq("R4", prot_map, 32'h8020_0001);
    expect_eq("R4", lock_map, 32'h8020_0001);
    do_chk("R4", 3'd1, sec_addr(31, 0));
    do_chk("R7", 3'd4, 21'd0);
  endtask

  task automatic t_same_cycle();
    do_cmd("R9", 3'd1, sec_addr(9, 0));
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_addr = sec_addr(9, 0);
    chk_valid = 1'b1; chk_kind = 3'd0; chk_addr = sec_addr(9, 16'h0040);
    @(negedge clk);
    cmd_valid = 1'b0; chk_valid = 1'b0;
    model_cmd(3'd2, sec_addr(9, 0));
    expect_eq("R9", {30'd0, rsp_valid, rsp_permit}, 32'd2);
    expect_eq("R9", {31'd0, prot_map[9]}, 32'd0);
    do_chk("R9", 3'd0, sec_addr(9, 16'h0040));
  endtask

  task automatic t_bad_kind();
    do_chk("R10", 3'd5, sec_addr(9, 0));
    do_chk("R8", 3'd0, sec_addr(9, 0));
    do_chk("R10", 3'd7, sec_addr(10, 0));
    do_chk("R10", 3'd6, sec_addr(9, 0));
    @(negedge clk);
    expect_eq("R8", {31'd0, err_flag}, 32'd1);
    expect_eq("R6", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    m_prot = '1; m_lock = '0;
    t_reset();
    t_single();
    t_global();
    t_chip();
    t_access();
    t_wp();
    t_lock();
    t_same_cycle();
    t_bad_kind();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule